// File: doc/BRIEF.md
# Serial Clock Ratio Monitor

This block watches the word-select (frame) clock and the bit clock of an audio serial port that is running as a clock slave. Both clocks come from outside but are derived synchronously from the master clock that drives this block. The monitor counts the rising bit-clock edges in each frame period and sorts the count into a ratio code. It then reports whether that ratio is permitted for the selected speed mode.

Single-speed operation permits 48, 64 or 128 bit clocks per frame. Double-speed and quad-speed operation permit only 48 or 64. A ratio is reported as valid only once two consecutive whole frame periods have given the same legal count. Any illegal period raises an error flag. That flag stays raised until reset, or until the speed-mode select changes.

Top module: `bclk_ratio_mon`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `ratio_code` is 2'b11, `ratio_valid` is 0 and `ratio_err` is 0.
- R2: A measurement is the number of rising `bit_clk` edges between two successive rising `frame_clk` edges. The partial period before the first rising `frame_clk` edge after reset is never measured.
- R3: The code of a measurement is 2'b00 for 48, 2'b01 for 64, 2'b10 for 128 and 2'b11 for any other count. `ratio_code` shows the code of the latest measurement.
- R4: With `speed_sel` = 2'b00 (single speed), counts of 48, 64 and 128 are legal.
- R5: With `speed_sel` = 2'b01 (double), 2'b10 (quad) or 2'b11 (treated as quad), only 48 and 64 are legal. A count of 128 gives code 2'b11.
- R6: `ratio_valid` is 1 only when the latest two measurements since reset or the last speed change are equal and legal. A differing or illegal measurement clears it.
- R7: An illegal measurement sets `ratio_err`. Later legal measurements leave it set.
- R8: A change of `speed_sel` clears `ratio_err` and `ratio_valid`, sets `ratio_code` to 2'b11 and forgets the previous measurement, all on the next clock edge.
- R9: The edge counter saturates at 2**CNT_W-1. A period longer than that reports code 2'b11 and never wraps into a legal count.
- R10: The outputs take the result of a finished period on the fourth rising `clk` edge after `frame_clk` rises at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all logic runs on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| speed_sel | input | 2 | Speed mode: 00 single, 01 double, 10 quad, 11 quad |
| frame_clk | input | 1 | Word-select clock from the external master |
| bit_clk | input | 1 | Serial bit clock from the external master |
| ratio_code | output | 2 | Code of the latest measurement (see R3) |
| ratio_valid | output | 1 | Two equal legal measurements in a row |
| ratio_err | output | 1 | Sticky flag for an illegal measurement |

## Verification
The assertions assume that each high and each low phase of `frame_clk` and `bit_clk` lasts at least two `clk` cycles, so the synchronisers see every edge. They also assume that `speed_sel` only changes from a register in the `clk` domain. The stimulus meets both assumptions. It drives every input on the falling `clk` edge and gives each bit-clock phase two `clk` cycles. It moves `frame_clk` only while `bit_clk` is low, as a real port master does.

// File: rtl/brm_pkg.sv
package brm_pkg;

    typedef enum logic [1:0] {
        SPD_SINGLE   = 2'b00,
        SPD_DOUBLE   = 2'b01,
        SPD_QUAD     = 2'b10,
        SPD_QUAD_ALT = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        RAT_48  = 2'b00,
        RAT_64  = 2'b01,
        RAT_128 = 2'b10,
        RAT_BAD = 2'b11
    } ratio_e;

    localparam int unsigned MEAS_W   = 16;
    localparam int unsigned BITS_48  = 48;
    localparam int unsigned BITS_64  = 64;
    localparam int unsigned BITS_128 = 128;

    typedef struct packed {
        logic              done;
        logic [MEAS_W-1:0] bits;
    } meas_t;

    function automatic logic allows_128(input speed_e spd);
        return spd == SPD_SINGLE;
    endfunction

    function automatic ratio_e classify(input logic [MEAS_W-1:0] bits,
                                        input speed_e spd);
        if (bits == MEAS_W'(BITS_48))
            return RAT_48;
        else if (bits == MEAS_W'(BITS_64))
            return RAT_64;
        else if (bits == MEAS_W'(BITS_128) && allows_128(spd))
            return RAT_128;
        else
            return RAT_BAD;
    endfunction

endpackage

// File: rtl/brm_sync.sv
module brm_sync #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_lane
        logic meta_q, sync_q, last_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= async_in[i];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign rise[i] = sync_q & ~last_q;

        assert_edge_single_R2: assert property (@(posedge clk) disable iff (rst)
            rise[i] |=> !rise[i]);
    end
endmodule

// File: rtl/brm_period_counter.sv
module brm_period_counter
    import brm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  frame_rise,
    input  logic  bit_rise,
    output meas_t meas
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            armed     <= 1'b0;
            meas.done <= 1'b0;
            meas.bits <= '0;
        end else begin
            meas.done <= 1'b0;
            if (frame_rise) begin
                if (armed) begin
                    meas.done <= 1'b1;
                    meas.bits <= MEAS_W'(cnt);
                end
                armed <= 1'b1;
                cnt   <= bit_rise ? CNT_W'(1) : '0;
            end else if (bit_rise && cnt != CNT_MAX) begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !frame_rise) |=> (cnt == CNT_MAX));

    assert_no_done_unarmed_R2: assert property (@(posedge clk) disable iff (rst)
        (!armed) |=> !meas.done);
endmodule

// File: rtl/brm_judge.sv
module brm_judge
    import brm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  speed_e speed_sel,
    input  meas_t  meas,
    output ratio_e code,
    output logic   valid,
    output logic   err
);
    speed_e speed_q;
    ratio_e prev_q;
    logic   have_prev;
    logic   spd_chg;
    ratio_e cls;

    always_comb begin
        spd_chg = (speed_sel != speed_q);
        cls     = classify(meas.bits, speed_q);
    end

    always_ff @(posedge clk) begin
        if (rst || spd_chg) begin
            speed_q   <= speed_sel;
            code      <= RAT_BAD;
            prev_q    <= RAT_BAD;
            have_prev <= 1'b0;
            valid     <= 1'b0;
            err       <= 1'b0;
        end else if (meas.done) begin
            code      <= cls;
            prev_q    <= cls;
            have_prev <= 1'b1;
            valid     <= (cls != RAT_BAD) && have_prev && (prev_q == cls);
            if (cls == RAT_BAD)
                err <= 1'b1;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (code == RAT_BAD && !valid && !err));

    assert_valid_legal_R6: assert property (@(posedge clk) disable iff (rst)
        valid |-> (code != RAT_BAD));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (err && !spd_chg) |=> err);

    assert_chg_clears_R8: assert property (@(posedge clk) disable iff (rst)
        spd_chg |=> (!err && !valid && code == RAT_BAD));

    assert_fast_no128_R5: assert property (@(posedge clk) disable iff (rst)
        (code == RAT_128) |-> (speed_q == SPD_SINGLE));
endmodule

// File: rtl/bclk_ratio_mon.sv
module bclk_ratio_mon
    import brm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] speed_sel,
    input  logic       frame_clk,
    input  logic       bit_clk,
    output logic [1:0] ratio_code,
    output logic       ratio_valid,
    output logic       ratio_err
);
    localparam int unsigned N_LANES = 2;
    localparam int unsigned LANE_FRAME = 1;
    localparam int unsigned LANE_BIT   = 0;

    logic [N_LANES-1:0] rises;
    meas_t              meas;
    ratio_e             code;

    brm_sync #(.N(N_LANES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in ({frame_clk, bit_clk}),
        .rise     (rises)
    );

    brm_period_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .frame_rise (rises[LANE_FRAME]),
        .bit_rise   (rises[LANE_BIT]),
        .meas       (meas)
    );

    brm_judge u_judge (
        .clk       (clk),
        .rst       (rst),
        .speed_sel (speed_e'(speed_sel)),
        .meas      (meas),
        .code      (code),
        .valid     (ratio_valid),
        .err       (ratio_err)
    );

    assign ratio_code = code;
endmodule

// File: tb/bclk_ratio_mon_test.sv
module bclk_ratio_mon_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] speed_sel = 2'b00;
    logic       frame_clk = 1'b0;
    logic       bit_clk = 1'b0;
    logic [1:0] ratio_code;
    logic       ratio_valid;
    logic       ratio_err;

    int compared = 0;
    int mismatched = 0;

    always #4 clk = ~clk;

    bclk_ratio_mon uut (
        .clk(clk), .rst(rst), .speed_sel(speed_sel),
        .frame_clk(frame_clk), .bit_clk(bit_clk),
        .ratio_code(ratio_code), .ratio_valid(ratio_valid), .ratio_err(ratio_err)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input logic [1:0] c, input logic v, input logic e);
        chk({tag, " code"}, 32'(ratio_code), 32'(c));
        chk({tag, " valid"}, 32'(ratio_valid), 32'(v));
        chk({tag, " err"}, 32'(ratio_err), 32'(e));
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk);
        rst = 1'b1; speed_sel = sel; frame_clk = 1'b0; bit_clk = 1'b0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic run_frames(input int n, input int nbits);
        for (int f = 0; f < n; f++) begin
            for (int b = 0; b < nbits; b++) begin
                bit_clk = 1'b0;
                frame_clk = (b < nbits / 2);
                cyc(2);
                bit_clk = 1'b1;
                cyc(2);
            end
        end
    endtask

    task automatic t_single_64;
        do_reset(2'b00);
        run_frames(3, 64);
        chk_out("R3 R4 R6 single 64", 2'b01, 1'b1, 1'b0);
    endtask

    task automatic t_partial_first;
        do_reset(2'b00);
        for (int i = 0; i < 10; i++) begin
            bit_clk = 1'b0; cyc(2); bit_clk = 1'b1; cyc(2);
        end
        run_frames(2, 64);
        chk_out("R2 R6 partial discarded one measurement", 2'b01, 1'b0, 1'b0);
    endtask

    task automatic t_single_128;
        do_reset(2'b00);
        run_frames(3, 128);
        chk_out("R4 single 128", 2'b10, 1'b1, 1'b0);
    endtask

    task automatic t_quad_48;
        do_reset(2'b10);
        run_frames(3, 48);
        chk_out("R3 R5 quad 48", 2'b00, 1'b1, 1'b0);
    endtask

    task automatic t_double_128;
        do_reset(2'b01);
        run_frames(3, 128);
        chk_out("R5 R7 double 128", 2'b11, 1'b0, 1'b1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        cyc(1);
        chk_out("R1 during reset", 2'b11, 1'b0, 1'b0);
        rst = 1'b0;
        cyc(1);
        chk_out("R1 after reset", 2'b11, 1'b0, 1'b0);
    endtask

    task automatic t_alt_quad_128;
        do_reset(2'b11);
        run_frames(3, 128);
        chk_out("R5 sel 11 128", 2'b11, 1'b0, 1'b1);
        do_reset(2'b11);
        run_frames(3, 64);
        chk_out("R5 sel 11 64", 2'b01, 1'b1, 1'b0);
    endtask

    task automatic t_mismatch;
        do_reset(2'b00);
        run_frames(1, 64);
        run_frames(1, 48);
        run_frames(1, 64);
        run_frames(1, 48);
        chk_out("R6 alternating legal", 2'b01, 1'b0, 1'b0);
    endtask

    task automatic t_sticky_then_change;
        do_reset(2'b00);
        run_frames(2, 32);
        chk_out("R7 illegal 32", 2'b11, 1'b0, 1'b1);
        run_frames(3, 64);
        chk_out("R7 sticky after good", 2'b01, 1'b1, 1'b1);
        speed_sel = 2'b01;
        cyc(1);
        chk_out("R8 speed change clears", 2'b11, 1'b0, 1'b0);
        run_frames(1, 64);
        chk_out("R8 history forgotten", 2'b01, 1'b0, 1'b0);
        run_frames(1, 64);
        chk_out("R8 valid again", 2'b01, 1'b1, 1'b0);
    endtask

    task automatic t_saturate;
        do_reset(2'b00);
        run_frames(2, 320);
        chk_out("R9 saturate 320", 2'b11, 1'b0, 1'b1);
    endtask

    task automatic t_latency;
        do_reset(2'b00);
        run_frames(2, 48);
        run_frames(1, 64);
        chk_out("R10 before edge", 2'b00, 1'b1, 1'b0);
        bit_clk = 1'b0;
        frame_clk = 1'b1;
        cyc(3);
        chk("R10 code held three edges", 32'(ratio_code), 32'(2'b00));
        cyc(1);
        chk_out("R10 updated fourth edge", 2'b01, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        cyc(2);
        chk_out("R1 initial reset", 2'b11, 1'b0, 1'b0);
        t_single_64();
        t_partial_first();
        t_single_128();
        t_quad_48();
        t_double_128();
        t_reset();
        t_alt_quad_128();
        t_mismatch();
        t_sticky_then_change();
        t_saturate();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule